// File: doc/BRIEF.md
# Byte-to-Halfword Unpacking Load Datapath

This block sits at the end of a load pipeline. It takes the raw little-endian word that the memory port returns and forms the value that is written back to the register file. For the unpacking loads, each loaded byte is widened into its own 16-bit halfword lane of the destination. Each lane is zero-extended or sign-extended on its own. The 2-element form yields one 32-bit register, and the 4-element form yields a 64-bit register pair. The same unit also handles the plain signed-byte, unsigned-byte and signed-halfword loads, so one writeback path serves all of them.

A 4-bit load-kind code selects the operation. The result, the pair flag and the valid strobe are registered one cycle after the load-data strobe. Codes that the block does not recognise raise an illegal flag instead of a valid strobe. Address generation, the memory and the register file are outside the block.

Top module: `byte_unpack_load`

## Requirements
- R1: While reset is asserted and right after it, `wb_valid`, `wb_illegal` and `wb_pair` are 0 and `wb_data` is all zero.
- R2: Kind 4'b0011 (unsigned, 2 lanes) puts byte i (bits 8i+7..8i of `ld_data`, i = 0..1) into bits 16i+15..16i of `wb_data`, with a zero upper byte in each lane. Bits 63..32 are zero.
- R3: Kind 4'b0001 (signed, 2 lanes) does the same as R2, except that the upper byte of each lane copies bit 7 of that lane's byte. For example, bytes 0x81, 0x02 give 0x0002FF81.
- R4: Kind 4'b0101 (unsigned, 4 lanes) fills all four lanes from bytes 0..3 with zero extension. For example, bytes 0x81, 0x02, 0x83, 0x04 give 0x0004008300020081.
- R5: Kind 4'b0111 (signed, 4 lanes) fills all four lanes from bytes 0..3, with each lane sign-extended from its own byte.
- R6: Kind 4'b1000 (signed byte) writes byte 0 sign-extended to 32 bits, and bits 63..32 are zero.
- R7: Kind 4'b1001 (unsigned byte) writes byte 0 zero-extended, and bits 63..32 are zero.
- R8: Kind 4'b1010 (signed halfword) writes bits 15..0 sign-extended to 32 bits, and bits 63..32 are zero.
- R9: `wb_pair` is 1 with a valid result only for kinds 4'b0101 and 4'b0111. All other legal kinds give 0.
- R10: An accepted load gives `wb_valid` high for exactly the one cycle after the cycle in which `ld_valid` was high. In a cycle with no load, `wb_valid` is 0 and `wb_data` and `wb_pair` keep their values.
- R11: Any other kind code with `ld_valid` pulses `wb_illegal` one cycle later, keeps `wb_valid` low, and leaves `wb_data` and `wb_pair` unchanged.
- R12: Bytes of `ld_data` above those the selected kind uses have no effect on `wb_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load data and kind are present this cycle |
| ld_kind | input | 4 | Load-kind code |
| ld_data | input | 64 | Raw load data, byte 0 at the lowest address in bits 7..0 |
| wb_valid | output | 1 | Writeback result is valid |
| wb_data | output | 64 | Writeback value |
| wb_pair | output | 1 | Result targets a register pair |
| wb_illegal | output | 1 | Previous load carried an unsupported kind |

## Verification
The hardest case to reach is an illegal kind arriving right after a legal load. Only in that case can an illegal code that corrupts the held result or the pair flag be seen, because the prior value must be known and non-trivial. The stimulus therefore puts illegal codes directly after 4-lane signed loads of bytes that all have their top bit set. The random phase also draws all 16 kind codes with full 64-bit random data, so high unused bytes are present whenever they might leak into lanes that should be zero.

// File: rtl/byte_unpack_load.sv
module byte_unpack_load #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_valid,
  input  logic [3:0]                  ld_kind,
  input  logic [2*BYTE_W*LANES-1:0]   ld_data,
  output logic                        wb_valid,
  output logic [2*BYTE_W*LANES-1:0]   wb_data,
  output logic                        wb_pair,
  output logic                        wb_illegal
);
  localparam int LANE_W = 2 * BYTE_W;
  localparam int OUT_W  = LANE_W * LANES;
  localparam int HALF_W = OUT_W / 2;
  localparam int NARROW = LANES / 2;

  logic legal, unpack, wide, sext, sc_byte, sc_half;

  always_comb begin
    legal = 1'b1; unpack = 1'b0; wide = 1'b0; sext = 1'b0;
    sc_byte = 1'b0; sc_half = 1'b0;
    case (ld_kind)
      4'b0011: unpack = 1'b1;
      4'b0001: begin unpack = 1'b1; sext = 1'b1; end
      4'b0101: begin unpack = 1'b1; wide = 1'b1; end
      4'b0111: begin unpack = 1'b1; wide = 1'b1; sext = 1'b1; end
      4'b1000: begin sc_byte = 1'b1; sext = 1'b1; end
      4'b1001: sc_byte = 1'b1;
      4'b1010: begin sc_half = 1'b1; sext = 1'b1; end
      default: legal = 1'b0;
    endcase
  end

  logic [OUT_W-1:0] lane_val, byte_val, half_val, next_val;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BYTE_W-1:0] b;
    logic              fill;
    assign b    = ld_data[i*BYTE_W +: BYTE_W];
    assign fill = sext & b[BYTE_W-1];
    if (i < NARROW) begin : g_lo
      assign lane_val[i*LANE_W +: LANE_W] = {{BYTE_W{fill}}, b};
    end else begin : g_hi
      assign lane_val[i*LANE_W +: LANE_W] = wide ? {{BYTE_W{fill}}, b} : '0;
    end
  end

  assign byte_val = {{HALF_W{1'b0}},
                     {(HALF_W-BYTE_W){sext & ld_data[BYTE_W-1]}},
                     ld_data[BYTE_W-1:0]};
  assign half_val = {{HALF_W{1'b0}},
                     {(HALF_W-LANE_W){ld_data[LANE_W-1]}},
                     ld_data[LANE_W-1:0]};

  assign next_val = unpack  ? lane_val :
                    sc_byte ? byte_val :
                    sc_half ? half_val : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid   <= 1'b0;
      wb_illegal <= 1'b0;
      wb_pair    <= 1'b0;
      wb_data    <= '0;
    end else begin
      wb_valid   <= ld_valid & legal;
      wb_illegal <= ld_valid & ~legal;
      if (ld_valid && legal) begin
        wb_data <= next_val;
        wb_pair <= wide;
      end
    end
  end

  p_pair_wide_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_pair == ($past(ld_kind) == 4'b0101 || $past(ld_kind) == 4'b0111)));
  p_valid_after_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(ld_valid));
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_valid) |-> ($stable(wb_data) && $stable(wb_pair) && !wb_valid));
  p_illegal_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_illegal |-> (!wb_valid && $stable(wb_data) && $stable(wb_pair)));
  p_narrow_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_pair) |-> (wb_data[OUT_W-1:HALF_W] == '0));
endmodule

// File: tb/byte_unpack_load_test.sv
`timescale 1ns/1ps
module byte_unpack_load_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [3:0]  ld_kind = 4'h0;
  logic [63:0] ld_data = 64'h0;
  logic        wb_valid, wb_pair, wb_illegal;
  logic [63:0] wb_data;

  int checks = 0;
  int fails  = 0;
  logic [63:0] last_data = 64'h0;
  logic        last_pair = 1'b0;

  always #2.5 clk = ~clk;

  byte_unpack_load uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_kind(ld_kind),
    .ld_data(ld_data), .wb_valid(wb_valid), .wb_data(wb_data),
    .wb_pair(wb_pair), .wb_illegal(wb_illegal)
  );

  function automatic bit is_legal(input logic [3:0] k);
    return k inside {4'b0011, 4'b0001, 4'b0101, 4'b0111, 4'b1000, 4'b1001, 4'b1010};
  endfunction

  function automatic bit is_pair(input logic [3:0] k);
    return (k == 4'b0101) || (k == 4'b0111);
  endfunction

  function automatic logic [63:0] model(input logic [3:0] k, input logic [63:0] d);
    logic [63:0] r = 64'h0;
    int n = 0;
    bit s = 0;
    case (k)
      4'b0011: n = 2;
      4'b0001: begin n = 2; s = 1; end
      4'b0101: n = 4;
      4'b0111: begin n = 4; s = 1; end
      4'b1000: r[31:0] = {{24{d[7]}}, d[7:0]};
      4'b1001: r[31:0] = {24'h0, d[7:0]};
      4'b1010: r[31:0] = {{16{d[15]}}, d[15:0]};
      default: r = 64'h0;
    endcase
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = d[8*i +: 8];
      r[16*i +: 16] = {(s && b[7]) ? 8'hFF : 8'h00, b};
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [3:0] k, input logic [63:0] d, input string tag);
    @(negedge clk);
    ld_valid = 1'b1; ld_kind = k; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
    if (is_legal(k)) begin
      last_data = model(k, d);
      last_pair = is_pair(k);
      chk({tag, " R10 valid"}, {63'h0, wb_valid}, 64'h1);
      chk({tag, " R11 illegal low"}, {63'h0, wb_illegal}, 64'h0);
    end else begin
      chk({tag, " R11 valid low"}, {63'h0, wb_valid}, 64'h0);
      chk({tag, " R11 illegal"}, {63'h0, wb_illegal}, 64'h1);
    end
    chk({tag, " data"}, wb_data, last_data);
    chk({tag, " R9 pair"}, {63'h0, wb_pair}, {63'h0, last_pair});
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk({tag, " R10 idle valid"}, {63'h0, wb_valid}, 64'h0);
    chk({tag, " R10 idle data"}, wb_data, last_data);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {63'h0, wb_valid}, 64'h0);
    chk("R1 reset data", wb_data, 64'h0);
    chk("R1 reset pair/illegal", {62'h0, wb_pair, wb_illegal}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {wb_data[61:0], wb_pair, wb_valid}, 64'h0);

    do_load(4'b0011, 64'h0000_0000_0000_0281, "R2 u2");
    chk("R2 value", wb_data, 64'h0000_0000_0002_0081);
    do_load(4'b0001, 64'h0000_0000_0000_0281, "R3 s2");
    chk("R3 value", wb_data, 64'h0000_0000_0002_FF81);
    do_load(4'b0101, 64'h0000_0000_0483_0281, "R4 u4");
    chk("R4 value", wb_data, 64'h0004_0083_0002_0081);
    do_load(4'b0111, 64'h0000_0000_0483_0281, "R5 s4");
    chk("R5 value", wb_data, 64'h0004_FF83_0002_FF81);
    do_load(4'b1000, 64'h0000_0000_0000_0081, "R6 sbyte");
    chk("R6 value", wb_data, 64'h0000_0000_FFFF_FF81);
    do_load(4'b1001, 64'hFFFF_FFFF_FFFF_FF81, "R7 ubyte");
    chk("R7 value", wb_data, 64'h0000_0000_0000_0081);
    do_load(4'b1010, 64'h0000_0000_0000_8281, "R8 shalf");
    chk("R8 value", wb_data, 64'h0000_0000_FFFF_8281);
    do_load(4'b0011, 64'hFFFF_FFFF_FFFF_0281, "R12 u2 junk high");
    chk("R12 value", wb_data, 64'h0000_0000_0002_0081);
    do_load(4'b0111, 64'hA5A5_A5A5_8080_8080, "R12 s4 junk high");
    chk("R12 s4 value", wb_data, 64'hFF80_FF80_FF80_FF80);
    do_load(4'b0000, 64'h1234_5678_9ABC_DEF0, "R11 code0");
    chk("R11 held data", wb_data, 64'hFF80_FF80_FF80_FF80);
    do_load(4'b1111, 64'h0, "R11 code15");
    idle_check("R10 after illegal");
    idle_check("R10 idle two");

    for (int n = 0; n < 400; n++) begin
      logic [3:0]  k;
      logic [63:0] d;
      k = 4'($urandom_range(0, 15));
      d = {$urandom, $urandom};
      do_load(k, d, "rand");
      if ($urandom_range(0, 3) == 0) idle_check("rand idle");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule